// File: doc/BRIEF.md
# Serial Result Port of a Successive-Approximation Converter

This block is a synthesizable stand-in for the digital face of an 18-bit sampling converter. It is meant for simulation or emulation benches where a real converter would sit. A host drives the convert strobe, the serial clock and the serial data input. A separate source supplies each new conversion result as a parallel word with a one-cycle valid strobe. The block answers on a serial data line with an output-enable that models the line's high-impedance state.

A rising convert edge starts a conversion of a fixed, parameterised number of system-clock cycles. The same edge captures the data-input level, which picks the interface mode for that conversion:
- In select mode, the result leaves MSB first, one bit per serial-clock falling edge. The line is driven only while the host holds the convert or data input low. An optional completion marker comes first: the line goes low-to-high before the data.
- In chain mode, the result is followed by whatever arrives on the data input, delayed by one word length, so several devices can share a single return line.

All inputs are taken as synchronous to the system clock. Edges are found by comparing each input with its value one clock earlier.

Top module: `ssp_sar_port`

## Requirements
- R1: After reset, and whenever no conversion or readout is in progress, the output-enable is low and the data output is 0.
- R2: The data-input level at a convert rising edge picks the mode: low selects chain mode, high selects select mode.
- R3: A conversion lasts exactly CONV_CYC system-clock cycles, counted from the clock edge that detects the convert rise. During a conversion, serial-clock edges and further convert rises have no effect, and the data output is 0.
- R4: In select mode the result appears MSB (bit 17) first. Each serial-clock falling edge presents the next lower bit, down to bit 0, so the word is returned unchanged as an 18-bit two's-complement pattern.
- R5: In select mode the output-enable is high only while the convert input or the data input is low. It drops and stays low after the falling edge that ends bit 0, until the next conversion starts.
- R6: In select mode, if the convert input or the data input is low when the conversion ends, the output is 1 (the completion marker) until the first serial-clock falling edge. The MSB follows that edge, so 19 falling edges end the readout.
- R7: In chain mode the result leaves MSB first on falling edges. The data-input level sampled at falling edge k is then presented from edge k+17, so a host sampling at each falling edge reads it exactly 18 edges later.
- R8: The result word is captured when its valid strobe is high. The last captured word before a conversion ends is the one shifted out; the word input is ignored while the strobe is low.
- R9: In chain mode the output-enable is high from the convert rise onward, whatever the convert and data levels are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv | input | 1 | Convert strobe; rising edge starts a conversion |
| sck | input | 1 | Serial clock; falling edges advance the output |
| sdi | input | 1 | Mode select at the convert rise, select line or chain data afterwards |
| res_data | input | RES_W | Parallel conversion result, two's complement |
| res_vld | input | 1 | Capture strobe for res_data |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output-enable; low models high impedance |

## Verification
The assertions assume that the convert, serial-clock and data inputs change only between system-clock edges. They also assume each level is held for at least one clock, so every edge is seen by exactly one sampling edge. The bench drives every input on the falling system-clock edge and holds each serial-clock phase for two clocks. The assertions further assume that the host keeps the select lines steady across the last conversion cycle. The bench changes them only well away from the cycle in which a conversion ends.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_DATA = 2'd2
  } ssp_state_e;
endpackage

// File: rtl/ssp_edge.sv
module ssp_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise[i] = din[i] & ~prev_q[i];
    assign fall[i] = ~din[i] & prev_q[i];
  end
endmodule

// File: rtl/ssp_conv_timer.sv
module ssp_conv_timer #(
  parameter int CONV_CYC = 110
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int TW = $clog2(CONV_CYC + 1);

  logic          run_q, run_d;
  logic [TW-1:0] cnt_q, cnt_d;

  assign done = run_q && (cnt_q == TW'(1));

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (start && !run_q) begin
      run_d = 1'b1;
      cnt_d = TW'(CONV_CYC);
    end else if (run_q) begin
      if (done) run_d = 1'b0;
      cnt_d = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         shift_in,
  output logic         msb
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = load_val;
    else if (shift) sr_d = {sr_q[W-2:0], shift_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign msb = sr_q[W-1];
endmodule

// File: rtl/ssp_sar_port.sv
module ssp_sar_port
  import ssp_pkg::*;
#(
  parameter int RES_W    = 18,
  parameter int CONV_CYC = 110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv,
  input  logic             sck,
  input  logic             sdi,
  input  logic [RES_W-1:0] res_data,
  input  logic             res_vld,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam int BW = $clog2(RES_W);

  ssp_state_e       state_q, state_d;
  logic             chain_q, chain_d;
  logic             marker_q, marker_d;
  logic [BW-1:0]    bitcnt_q, bitcnt_d;
  logic [RES_W-1:0] hold_q;

  logic [1:0] rise_v, fall_v;
  logic       cnv_rise, sck_fall, sel_low, start, tmr_done, shift, msb;

  ssp_edge #(.N(2)) i_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sck, cnv}),
    .rise (rise_v),
    .fall (fall_v)
  );

  assign cnv_rise = rise_v[0];
  assign sck_fall = fall_v[1];
  assign sel_low  = ~cnv | ~sdi;
  assign start    = cnv_rise && (state_q != ST_CONV);

  ssp_conv_timer #(.CONV_CYC(CONV_CYC)) i_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .done (tmr_done)
  );

  assign shift = (state_q == ST_DATA) && sck_fall && (chain_q || !marker_q);

  ssp_shifter #(.W(RES_W)) i_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_done),
    .load_val(hold_q),
    .shift   (shift),
    .shift_in(chain_q & sdi),
    .msb     (msb)
  );

  // result holding register with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (res_vld) hold_q <= res_data;
  end

  always_comb begin
    state_d  = state_q;
    chain_d  = chain_q;
    marker_d = marker_q;
    bitcnt_d = bitcnt_q;
    if (start) begin
      state_d  = ST_CONV;
      chain_d  = ~sdi;
      marker_d = 1'b0;
      bitcnt_d = '0;
    end else begin
      unique case (state_q)
        ST_CONV: begin
          if (tmr_done) begin
            state_d  = ST_DATA;
            marker_d = !chain_q && sel_low;
          end
        end
        ST_DATA: begin
          if (sck_fall && !chain_q) begin
            if (marker_q) begin
              marker_d = 1'b0;
            end else if (bitcnt_q == BW'(RES_W - 1)) begin
              state_d = ST_IDLE;
            end else begin
              bitcnt_d = bitcnt_q + BW'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      chain_q  <= 1'b0;
      marker_q <= 1'b0;
      bitcnt_q <= '0;
    end else begin
      state_q  <= state_d;
      chain_q  <= chain_d;
      marker_q <= marker_d;
      bitcnt_q <= bitcnt_d;
    end
  end

  assign sdo    = (state_q == ST_DATA) && (marker_q || msb);
  assign sdo_oe = (state_q != ST_IDLE) && (chain_q || sel_low);
endmodule

// File: rtl/ssp_sar_port_chk.sv
module ssp_sar_port_chk
  import ssp_pkg::*;
#(
  parameter int CONV_CYC = 110
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cnv,
  input logic       sdi,
  input logic       sdo,
  input logic       sdo_oe,
  input ssp_state_e state_q,
  input logic       chain_q,
  input logic       tmr_done
);
  localparam int CW = $clog2(CONV_CYC + 1) + 1;

  logic [CW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  len_q <= '0;
    else if (state_q == ST_CONV) len_q <= len_q + CW'(1);
    else                         len_q <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!sdo_oe && !sdo)); // R1

  AST_CONV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV) |-> (len_q < CW'(CONV_CYC))); // R3

  AST_CONV_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |-> ((state_q == ST_CONV) && (len_q == CW'(CONV_CYC - 1)))); // R3

  AST_SEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_q && cnv && sdi) |-> !sdo_oe); // R5

  AST_MARKER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_done && !chain_q && (!cnv || !sdi) && $stable(cnv) && $stable(sdi)) |=> sdo); // R6

  AST_CHAIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_q && (state_q != ST_IDLE)) |-> sdo_oe); // R9
endmodule

bind ssp_sar_port ssp_sar_port_chk #(.CONV_CYC(CONV_CYC)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnv     (cnv),
  .sdi     (sdi),
  .sdo     (sdo),
  .sdo_oe  (sdo_oe),
  .state_q (state_q),
  .chain_q (chain_q),
  .tmr_done(tmr_done)
);

// File: tb/test_ssp_sar_port.sv
module test_ssp_sar_port;
  localparam int W = 18;
  localparam int C = 12;

  logic         clk, rst_n, cnv, sck, sdi, res_vld;
  logic [W-1:0] res_data;
  logic         sdo, sdo_oe;
  int           n_chk = 0;
  int           n_err = 0;
  bit           finished = 0;

  ssp_sar_port #(.RES_W(W), .CONV_CYC(C)) i_ssp_sar_port (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi),
    .res_data(res_data), .res_vld(res_vld), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic fall_edge(input logic din);
    @(negedge clk); sck = 1'b1; sdi = din;
    @(negedge clk);
    @(negedge clk); sck = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic give_result(input logic [W-1:0] v);
    @(negedge clk); res_data = ~v; res_vld = 1'b1;   // R8 decoy first
    @(negedge clk); res_data = v;
    @(negedge clk); res_vld = 1'b0; res_data = v ^ 18'h15A5A;
  endtask

  function automatic logic pat(input int k);
    return logic'(((k * 7) >> 1) & 1);
  endfunction

  // select mode, select lines released during conversion
  task automatic cs_plain(input logic [W-1:0] v, input bit glitch);
    give_result(v);
    @(negedge clk); cnv = 1'b0; sdi = 1'b1;
    @(negedge clk); cnv = 1'b1;
    if (glitch) begin
      @(negedge clk); sck = 1'b1;
      @(negedge clk); sck = 1'b0;   // R3 fall inside conversion
      repeat (C - 1) @(negedge clk);
    end else begin
      repeat (C + 1) @(negedge clk);
    end
    chk("R5 oe while deselected", sdo_oe, 1'b0);
    cnv = 1'b0;
    @(negedge clk);
    chk("R5 oe when selected", sdo_oe, 1'b1);
    chk("R4 msb first", sdo, v[W-1]);
    for (int i = 1; i < W; i++) begin
      fall_edge(1'b1);
      chk("R4 bit order", sdo, v[W-1-i]);
    end
    fall_edge(1'b1);
    chk("R5 release after last bit", sdo_oe, 1'b0);
    chk("R1 quiet after readout", sdo, 1'b0);
  endtask

  // select mode with completion marker
  task automatic cs_busy(input logic [W-1:0] v);
    give_result(v);
    @(negedge clk); cnv = 1'b0; sdi = 1'b1;
    @(negedge clk); cnv = 1'b1;
    @(negedge clk); cnv = 1'b0;
    repeat (C - 1) @(negedge clk);
    chk("R3 still converting oe", sdo_oe, 1'b1);
    chk("R3 output low in conversion", sdo, 1'b0);
    @(negedge clk);
    chk("R6 marker high", sdo, 1'b1);
    fall_edge(1'b1);
    chk("R6 msb after marker", sdo, v[W-1]);
    for (int i = 1; i < W; i++) begin
      fall_edge(1'b1);
      chk("R6 bit order", sdo, v[W-1-i]);
    end
    chk("R6 still driven at bit 0", sdo_oe, 1'b1);
    fall_edge(1'b1);
    chk("R6 release after 19 falls", sdo_oe, 1'b0);
  endtask

  // chain mode with an ignored convert pulse inside the conversion
  task automatic chain_run(input logic [W-1:0] v);
    give_result(v);
    @(negedge clk); cnv = 1'b0; sdi = 1'b0;
    @(negedge clk); cnv = 1'b1;
    @(negedge clk); cnv = 1'b0; sdi = 1'b1;
    @(negedge clk); cnv = 1'b1;               // R3 rise ignored
    repeat (C - 2) @(negedge clk);
    chk("R9 oe during conversion", sdo_oe, 1'b1);
    chk("R3 conversion not restarted", sdo, 1'b0);
    @(negedge clk);
    chk("R2 chain mode kept", sdo_oe, 1'b1);
    chk("R7 msb first", sdo, v[W-1]);
    for (int k = 1; k <= 2 * W; k++) begin
      fall_edge(pat(k));
      if (k < W) chk("R7 result bits", sdo, v[W-1-k]);
      else       chk("R7 upstream delayed", sdo, pat(k - (W - 1)));
      chk("R9 oe in readout", sdo_oe, 1'b1);
    end
  endtask

  initial begin
    rst_n = 1'b0; cnv = 1'b0; sck = 1'b0; sdi = 1'b1;
    res_data = '0; res_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset oe", sdo_oe, 1'b0);
    chk("R1 reset sdo", sdo, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle oe", sdo_oe, 1'b0);
    for (int j = 0; j < 6; j++) begin
      logic [W-1:0] v;
      v = (j == 0) ? '0 : (j == 1) ? '1 : (j == 2) ? 18'h20000 :
          (j == 3) ? 18'h1FFFF : W'(j * 32'h1D3A7);
      cs_plain(v, j == 2);
    end
    cs_busy(18'h2C35A);
    cs_busy(18'h00001);
    chain_run(18'h3A5C3);
    chain_run(18'h1E0F1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule